// File: doc/BRIEF.md
# Coarse Block-Matching Motion Search Engine

This block finds a rough motion vector for one 16×16 luminance macroblock. The current block is first written into a local buffer through a write port. A start strobe then launches a search over a reference window. The candidate displacements lie on a 2-pel grid in both directions. The horizontal range is asymmetric. A mode bit, sampled at start, selects a much larger window.

The block reads the window one pixel per cycle through a coordinate port, and the pixel must come back in the same cycle. It gathers one window row segment into a row register. Then a one-dimensional array of `NPE` processing elements accumulates sums of absolute differences. There is one element per candidate column, and each element sees the same current pixel together with its own shifted reference pixel. After each group of columns, a leftmost-minimum picker merges the group's results into a running best. When the last candidate has been evaluated, the block pulses done and holds the best vector and its cost.

Top module: `me_coarse_search`

## Requirements
- R1: `best_sad` equals the sum over all 16×16 positions of |current − reference| at the chosen displacement. It is `SW` bits wide, and the largest possible value (255 × 256 = 65280 for 8-bit pixels) is reported without wrapping.
- R2: In normal mode (`wide`=0) the candidates are dx = H_MIN_N + 2h for h = 0 … H_CAND_N−1 and dy = V_MIN_N + 2v for v = 0 … NV_N−1. Column slots in the last group with h ≥ H_CAND_N are never selected.
- R3: In wide mode (`wide`=1) the same rule applies with H_MIN_W, H_CAND_W, V_MIN_W and NV_W.
- R4: `mv_x` and `mv_y` are signed two's complement values of `MVW` bits in half-pel units, equal to twice the pel displacement, so bit 0 is always 0.
- R5: When SADs tie, the candidate first in scan order is kept. Scan order takes dy ascending, and dx ascending within each dy.
- R6: `done` is high for exactly one cycle. It rises NV × NGRP × (BLK × (2·NPE − 2 + 2·BLK) + 1) rising edges after the edge that accepts `start`, where NGRP = ⌈H_CAND / NPE⌉ for the mode in use.
- R7: A `start` raised while a search is running is ignored. The running search keeps its mode, its result and its completion time.
- R8: After reset `done`, `mv_x`, `mv_y` and `best_sad` are 0. After `done`, the three result ports keep their values until the next accepted start.
- R9: For window coordinate (`win_y`, `win_x`), the pixel of displacement (dx, dy) at block position (row i, column j) is read at `win_x` = 2h + j, `win_y` = 2v + i. The pixel is taken from `win_pix` in the same cycle. Coordinates stay below 2·(NGRP·NPE − 1) + BLK horizontally and 2·(NV − 1) + BLK vertically for the mode in use.
- R10: A current pixel written with `cur_we`=1 at `cur_addr` = row × BLK + column is the one matched at that block position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a search when idle |
| wide | input | 1 | Mode sampled with start: 0 normal, 1 wide |
| cur_we | input | 1 | Current-block write enable |
| cur_addr | input | log2(BLK²) | Current-block pixel index, row × BLK + column |
| cur_pix | input | PW | Current-block pixel value |
| win_x | output | XW | Window column being read |
| win_y | output | YW | Window row being read |
| win_pix | input | PW | Window pixel at (win_y, win_x), same cycle |
| done | output | 1 | One-cycle completion pulse |
| mv_x | output | MVW | Best horizontal vector, half-pel units, signed |
| mv_y | output | MVW | Best vertical vector, half-pel units, signed |
| best_sad | output | SW | SAD of the best candidate |

## Verification
The bench uses a horizontal candidate count that is not a multiple of the element count, and it places an exact match in an unused slot of the last group. A design that does not mask that slot reports a vector outside the range. Tie patterns are arranged so that every candidate, or every candidate after the first row, scores zero. A comparator using ≤, or a scan that runs columns before rows, then returns a later vector. An all-white block against an all-black window gives the largest SAD, which catches an accumulator that is too narrow. A second start is injected mid-search with the other mode selected, which catches a controller that restarts or relatches the mode: its result and its completion count would both move.

// File: rtl/me_pkg.sv
// Package me_pkg
// Shared types for the coarse motion search engine.
// Assumes: nothing beyond IEEE 1800-2017.
package me_pkg;

    // Phases of the scan sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_CALC = 2'd2,
        ST_PICK = 2'd3
    } scan_state_t;

    // Integer maximum used for sizing counters and windows
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bit width needed to index n items (at least one bit)
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/me_pe.sv
// Module me_pe
// One processing element of the array: accumulates |cur - ref| for one
// candidate column. Assumes SW is wide enough for BLK*BLK differences.
module me_pe #(
    parameter int PW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [PW-1:0] cur_pix,
    input  logic [PW-1:0] ref_pix,
    output logic [SW-1:0] sad
);

    logic [PW-1:0] diff;
    logic [SW-1:0] acc;

    // Absolute difference of the two pixels
    always_comb begin
        diff = (cur_pix > ref_pix) ? (cur_pix - ref_pix) : (ref_pix - cur_pix);
    end

    // Accumulator: cleared at the start of a group, summed during calc
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + SW'(diff);
        end
    end

    assign sad = acc;

endmodule

// File: rtl/me_min_pick.sv
// Module me_min_pick
// Selects the lowest SAD among the enabled elements of one group; on a tie
// the lowest element index (leftmost column) wins. Purely combinational.
module me_min_pick #(
    parameter int N  = 32,
    parameter int SW = 16,
    parameter int IW = 5
) (
    input  logic [N-1:0][SW-1:0] sad_vec,
    input  logic [N-1:0]         mask,
    output logic [IW-1:0]        idx,
    output logic [SW-1:0]        min_sad,
    output logic                 any
);

    // Linear scan from the left, strict less-than keeps the first minimum
    always_comb begin
        any     = 1'b0;
        idx     = '0;
        min_sad = '1;
        for (int k = 0; k < N; k++) begin
            if (mask[k] && (!any || (sad_vec[k] < min_sad))) begin
                any     = 1'b1;
                idx     = IW'(k);
                min_sad = sad_vec[k];
            end
        end
    end

endmodule

// File: rtl/me_scan_ctrl.sv
// Module me_scan_ctrl
// Sequencer: for each vertical offset and column group, loads BLK window
// rows (each followed by BLK calc cycles), then one pick cycle.
// Assumes start is a level sampled only while idle; mode is latched.
module me_scan_ctrl
    import me_pkg::*;
#(
    parameter int NPE    = 32,
    parameter int BLK    = 16,
    parameter int NGRP_N = 4,
    parameter int NGRP_W = 7,
    parameter int NV_N   = 57,
    parameter int NV_W   = 113,
    localparam int L     = 2*(NPE-1) + BLK,
    localparam int CLW   = idx_w(L),
    localparam int BW    = idx_w(BLK),
    localparam int GW    = idx_w(imax(NGRP_N, NGRP_W)),
    localparam int VW    = idx_w(imax(NV_N, NV_W))
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           wide,
    output logic           busy,
    output logic           wide_q,
    output logic           load_en,
    output logic           calc_en,
    output logic           pick_en,
    output logic           last_pick,
    output logic           clr_acc,
    output logic           accept,
    output logic [CLW-1:0] col,
    output logic [BW-1:0]  blk_i,
    output logic [BW-1:0]  blk_j,
    output logic [GW-1:0]  grp,
    output logic [VW-1:0]  vrow
);

    scan_state_t  state;
    logic [GW-1:0] grp_last;
    logic [VW-1:0] vrow_last;

    // Last group / last vertical offset for the latched mode
    always_comb begin
        grp_last  = wide_q ? GW'(NGRP_W-1) : GW'(NGRP_N-1);
        vrow_last = wide_q ? VW'(NV_W-1)   : VW'(NV_N-1);
    end

    assign busy      = (state != ST_IDLE);
    assign accept    = (state == ST_IDLE) && start;
    assign load_en   = (state == ST_LOAD);
    assign calc_en   = (state == ST_CALC);
    assign pick_en   = (state == ST_PICK);
    assign last_pick = pick_en && (grp == grp_last) && (vrow == vrow_last);
    assign clr_acc   = load_en && (col == '0) && (blk_i == '0);

    // State and counter sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wide_q <= 1'b0;
            col    <= '0;
            blk_i  <= '0;
            blk_j  <= '0;
            grp    <= '0;
            vrow   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        wide_q <= wide;
                        col    <= '0;
                        blk_i  <= '0;
                        blk_j  <= '0;
                        grp    <= '0;
                        vrow   <= '0;
                        state  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (col == CLW'(L-1)) begin
                        col   <= '0;
                        state <= ST_CALC;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_CALC: begin
                    if (blk_j == BW'(BLK-1)) begin
                        blk_j <= '0;
                        if (blk_i == BW'(BLK-1)) begin
                            blk_i <= '0;
                            state <= ST_PICK;
                        end else begin
                            blk_i <= blk_i + 1'b1;
                            state <= ST_LOAD;
                        end
                    end else begin
                        blk_j <= blk_j + 1'b1;
                    end
                end
                default: begin
                    if (last_pick) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_LOAD;
                        if (grp == grp_last) begin
                            grp  <= '0;
                            vrow <= vrow + 1'b1;
                        end else begin
                            grp <= grp + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R7: the latched mode cannot change while a search runs
    a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(wide_q));

    // R9: row-buffer fill index stays inside the segment
    a_r9_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (int'(col) < L));

    // R2: vertical offset never passes the last one of the mode
    a_r2_vrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (vrow <= vrow_last));

endmodule

// File: rtl/me_coarse_search.sv
// Module me_coarse_search
// Coarse 2-pel full search of one BLK x BLK block over a reference window,
// NPE candidate columns at a time. Assumes the window pixel at (win_y,
// win_x) is returned combinationally and the current block is not
// rewritten during a search.
module me_coarse_search
    import me_pkg::*;
#(
    parameter int PW       = 8,
    parameter int BLK      = 16,
    parameter int NPE      = 32,
    parameter int H_MIN_N  = -112,
    parameter int H_CAND_N = 106,
    parameter int V_MIN_N  = -56,
    parameter int NV_N     = 57,
    parameter int H_MIN_W  = -210,
    parameter int H_CAND_W = 211,
    parameter int V_MIN_W  = -112,
    parameter int NV_W     = 113,
    parameter int MVW      = 10,
    localparam int SW      = $clog2(BLK*BLK*((1 << PW) - 1) + 1),
    localparam int NGRP_N  = (H_CAND_N + NPE - 1) / NPE,
    localparam int NGRP_W  = (H_CAND_W + NPE - 1) / NPE,
    localparam int L       = 2*(NPE-1) + BLK,
    localparam int WIN_W   = 2*(imax(NGRP_N, NGRP_W)*NPE - 1) + BLK,
    localparam int WIN_H   = 2*(imax(NV_N, NV_W) - 1) + BLK,
    localparam int XW      = idx_w(WIN_W),
    localparam int YW      = idx_w(WIN_H),
    localparam int CAW     = idx_w(BLK*BLK)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  wide,
    input  logic                  cur_we,
    input  logic [CAW-1:0]        cur_addr,
    input  logic [PW-1:0]         cur_pix,
    output logic [XW-1:0]         win_x,
    output logic [YW-1:0]         win_y,
    input  logic [PW-1:0]         win_pix,
    output logic                  done,
    output logic signed [MVW-1:0] mv_x,
    output logic signed [MVW-1:0] mv_y,
    output logic [SW-1:0]         best_sad
);

    localparam int CLW = idx_w(L);
    localparam int BW  = idx_w(BLK);
    localparam int GW  = idx_w(imax(NGRP_N, NGRP_W));
    localparam int VW  = idx_w(imax(NV_N, NV_W));
    localparam int IW  = idx_w(NPE);

    logic           busy, wide_q, load_en, calc_en, pick_en, last_pick;
    logic           clr_acc, accept;
    logic [CLW-1:0] col;
    logic [BW-1:0]  blk_i, blk_j;
    logic [GW-1:0]  grp;
    logic [VW-1:0]  vrow;

    logic [PW-1:0]          cur_mem [BLK*BLK];
    logic [PW-1:0]          row_buf [L];
    logic [CAW-1:0]         cur_rd_addr;
    logic [PW-1:0]          cur_bcast;
    logic [NPE-1:0][SW-1:0] pe_sad;
    logic [NPE-1:0]         pe_mask;
    logic [IW-1:0]          pick_idx;
    logic [SW-1:0]          pick_sad;
    logic                   pick_any;
    logic                   best_vld;
    logic signed [MVW-1:0]  cand_mvx, cand_mvy;

    me_scan_ctrl #(
        .NPE(NPE), .BLK(BLK),
        .NGRP_N(NGRP_N), .NGRP_W(NGRP_W),
        .NV_N(NV_N), .NV_W(NV_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
        .busy(busy), .wide_q(wide_q), .load_en(load_en), .calc_en(calc_en),
        .pick_en(pick_en), .last_pick(last_pick), .clr_acc(clr_acc),
        .accept(accept), .col(col), .blk_i(blk_i), .blk_j(blk_j),
        .grp(grp), .vrow(vrow)
    );

    // Window coordinates: group base column plus fill index, 2-pel row step
    assign win_x = load_en ? XW'(int'(grp)*2*NPE + int'(col)) : '0;
    assign win_y = load_en ? YW'(2*int'(vrow) + int'(blk_i))  : '0;

    // Current-block buffer write port
    always_ff @(posedge clk) begin
        if (cur_we) begin
            cur_mem[cur_addr] <= cur_pix;
        end
    end

    // Current pixel broadcast to all elements during calc
    assign cur_rd_addr = CAW'(int'(blk_i)*BLK + int'(blk_j));
    assign cur_bcast   = cur_mem[cur_rd_addr];

    // Row segment capture from the window stream
    always_ff @(posedge clk) begin
        if (load_en) begin
            row_buf[col] <= win_pix;
        end
    end

    // Element array: element k sees the segment shifted by 2k
    for (genvar k = 0; k < NPE; k++) begin : g_pe
        logic [CLW-1:0] ridx;
        assign ridx = CLW'(2*k) + CLW'(blk_j);

        me_pe #(.PW(PW), .SW(SW)) u_pe (
            .clk(clk), .rst_n(rst_n), .clr(clr_acc), .en(calc_en),
            .cur_pix(cur_bcast), .ref_pix(row_buf[ridx]), .sad(pe_sad[k])
        );

        // Slot k of this group is a real candidate only inside the range
        assign pe_mask[k] = (int'(grp)*NPE + k) <
                            (wide_q ? H_CAND_W : H_CAND_N);

        // R1: the picked SAD is never above any valid element's SAD
        a_r1_pick_is_min: assert property (@(posedge clk) disable iff (!rst_n)
            pick_en && pe_mask[k] |-> (pick_sad <= pe_sad[k]));
    end

    me_min_pick #(.N(NPE), .SW(SW), .IW(IW)) u_pick (
        .sad_vec(pe_sad), .mask(pe_mask),
        .idx(pick_idx), .min_sad(pick_sad), .any(pick_any)
    );

    // Vector of the group winner in half-pel units
    always_comb begin
        cand_mvx = MVW'(2*((wide_q ? H_MIN_W : H_MIN_N) +
                           2*(int'(grp)*NPE + int'(pick_idx))));
        cand_mvy = MVW'(2*((wide_q ? V_MIN_W : V_MIN_N) + 2*int'(vrow)));
    end

    // Running best: strict improvement only, so earlier candidates win ties
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_vld <= 1'b0;
            best_sad <= '0;
            mv_x     <= '0;
            mv_y     <= '0;
        end else if (accept) begin
            best_vld <= 1'b0;
        end else if (pick_en && pick_any && (!best_vld || (pick_sad < best_sad))) begin
            best_vld <= 1'b1;
            best_sad <= pick_sad;
            mv_x     <= cand_mvx;
            mv_y     <= cand_mvy;
        end
    end

    // Completion pulse, one cycle after the final pick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= last_pick;
        end
    end

    // R6: done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: the running best never gets worse within a search
    a_r5_not_worse: assert property (@(posedge clk) disable iff (!rst_n)
        pick_en && best_vld |=> (best_sad <= $past(best_sad)));

    // R8: results are held while idle and no start arrives
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(best_sad) && $stable(mv_x) && $stable(mv_y));

endmodule

// File: tb/test_me_coarse_search.sv
// Directed bench for me_coarse_search with a reduced search range.
module test_me_coarse_search;

    localparam int NPE = 4, BLK = 16;
    localparam int HMN = -4, HCN = 6, VMN = -2, NVN = 3;
    localparam int HMW = -8, HCW = 9, VMW = -4, NVW = 5;
    localparam int GN = (HCN + NPE - 1) / NPE;
    localparam int GWD = (HCW + NPE - 1) / NPE;
    localparam int WW = 2*(GWD*NPE - 1) + BLK;
    localparam int WH = 2*(NVW - 1) + BLK;
    localparam int XW = $clog2(WW), YW = $clog2(WH);
    localparam int GROUP_CYC = BLK*(2*NPE - 2 + 2*BLK) + 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0;
    logic cur_we = 1'b0;
    logic [7:0] cur_addr = '0, cur_pix = '0, win_pix;
    logic [XW-1:0] win_x;
    logic [YW-1:0] win_y;
    logic done;
    logic signed [9:0] mv_x, mv_y;
    logic [15:0] best_sad;

    logic [7:0] win_mem [WH][WW];
    logic [7:0] cur_ref [BLK*BLK];
    int n_tests = 0, n_fail = 0;
    bit addr_fault = 0;

    always #2.5 clk = ~clk;

    me_coarse_search #(
        .NPE(NPE), .H_MIN_N(HMN), .H_CAND_N(HCN), .V_MIN_N(VMN), .NV_N(NVN),
        .H_MIN_W(HMW), .H_CAND_W(HCW), .V_MIN_W(VMW), .NV_W(NVW)
    ) i_me_coarse_search (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
        .cur_we(cur_we), .cur_addr(cur_addr), .cur_pix(cur_pix),
        .win_x(win_x), .win_y(win_y), .win_pix(win_pix),
        .done(done), .mv_x(mv_x), .mv_y(mv_y), .best_sad(best_sad)
    );

    // Window memory model with same-cycle read
    always_comb begin
        if (int'(win_x) < WW && int'(win_y) < WH) win_pix = win_mem[win_y][win_x];
        else win_pix = 8'd0;
    end

    // Window bound monitor (R9)
    always @(negedge clk) begin
        if (rst_n && (int'(win_x) >= WW || int'(win_y) >= WH)) addr_fault = 1;
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int hashpix(input int y, input int x);
        return (x*37 + y*91 + x*y*13 + 7) & 255;
    endfunction

    task automatic fill_hash();
        for (int y = 0; y < WH; y++)
            for (int x = 0; x < WW; x++) win_mem[y][x] = 8'(hashpix(y, x));
    endtask

    task automatic fill_const(input int v);
        for (int y = 0; y < WH; y++)
            for (int x = 0; x < WW; x++) win_mem[y][x] = 8'(v);
    endtask

    task automatic cur_from_patch(input int h, input int v);
        for (int i = 0; i < BLK; i++)
            for (int j = 0; j < BLK; j++) cur_ref[i*BLK+j] = win_mem[2*v+i][2*h+j];
    endtask

    task automatic cur_const(input int val);
        for (int a = 0; a < BLK*BLK; a++) cur_ref[a] = 8'(val);
    endtask

    // Write the current block through the port (R10)
    task automatic write_cur();
        for (int a = 0; a < BLK*BLK; a++) begin
            @(negedge clk);
            cur_we = 1'b1; cur_addr = 8'(a); cur_pix = cur_ref[a];
        end
        @(negedge clk);
        cur_we = 1'b0;
    endtask

    // Reference model: scan order rows first, strict improvement
    task automatic model(input bit w, output int esad, output int emx, output int emy);
        int hmin, hc, vmin, nv, s;
        bit first;
        hmin = w ? HMW : HMN; hc = w ? HCW : HCN;
        vmin = w ? VMW : VMN; nv = w ? NVW : NVN;
        first = 1; esad = 0; emx = 0; emy = 0;
        for (int v = 0; v < nv; v++)
            for (int h = 0; h < hc; h++) begin
                s = 0;
                for (int i = 0; i < BLK; i++)
                    for (int j = 0; j < BLK; j++) begin
                        int d = int'(cur_ref[i*BLK+j]) - int'(win_mem[2*v+i][2*h+j]);
                        s += (d < 0) ? -d : d;
                    end
                if (first || s < esad) begin
                    first = 0; esad = s;
                    emx = 2*(hmin + 2*h); emy = 2*(vmin + 2*v);
                end
            end
    endtask

    // Launch a search, optionally re-pulse start mid-run; return edge count
    task automatic run_search(input bit w, input bit inject, output int cyc);
        @(negedge clk);
        start = 1'b1; wide = w;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = (inject && cyc == 100);
            if (inject && cyc == 100) wide = ~w;
        end
        start = 1'b0;
    endtask

    task automatic check_result(input bit w, input string tag);
        int esad, emx, emy;
        model(w, esad, emx, emy);
        check(best_sad == 16'(esad), {tag, " R1 sad"}, int'(best_sad), esad);
        check(int'(mv_x) == emx, {tag, " R2/R3 mv_x"}, int'(mv_x), emx);
        check(int'(mv_y) == emy, {tag, " R2/R3 mv_y"}, int'(mv_y), emy);
        check(mv_x[0] == 1'b0 && mv_y[0] == 1'b0, {tag, " R4 even vector"}, int'(mv_x), emx);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R8 reset done", int'(done), 0);
        check(best_sad == 16'd0, "R8 reset sad", int'(best_sad), 0);
        check(mv_x == 10'sd0 && mv_y == 10'sd0, "R8 reset mv", int'(mv_x), 0);
    endtask

    task automatic t_exact_normal();
        int cyc;
        fill_hash(); cur_from_patch(3, 1); write_cur();
        run_search(1'b0, 1'b0, cyc);
        check(cyc == NVN*GN*GROUP_CYC, "R6 latency normal", cyc, NVN*GN*GROUP_CYC);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
        check(best_sad == 16'd0, "R10 exact match sad", int'(best_sad), 0);
        check(int'(mv_x) == 4 && int'(mv_y) == 0, "R4 exact vector", int'(mv_x), 4);
        check_result(1'b0, "exact");
    endtask

    task automatic t_masked_slot();
        int cyc;
        fill_hash(); cur_from_patch(7, 0); write_cur();
        run_search(1'b0, 1'b0, cyc);
        check(int'(mv_x) != 2*(HMN + 14), "R2 masked slot not chosen", int'(mv_x), 0);
        check_result(1'b0, "masked");
    endtask

    task automatic t_tie_all();
        int cyc;
        fill_const(50); cur_const(50); write_cur();
        run_search(1'b0, 1'b0, cyc);
        check(int'(mv_x) == 2*HMN && int'(mv_y) == 2*VMN, "R5 full tie first", int'(mv_x), 2*HMN);
        check(best_sad == 16'd0, "R5 full tie sad", int'(best_sad), 0);
    endtask

    task automatic t_tie_row_order();
        int cyc;
        fill_const(50);
        for (int x = 0; x < WW; x++) begin win_mem[0][x] = 8'd200; win_mem[1][x] = 8'd200; end
        cur_const(50); write_cur();
        run_search(1'b0, 1'b0, cyc);
        check(int'(mv_x) == 2*HMN && int'(mv_y) == 2*(VMN + 2), "R5 row-first tie",
              int'(mv_y), 2*(VMN + 2));
    endtask

    task automatic t_wide();
        int cyc;
        fill_hash(); cur_from_patch(8, 4); write_cur();
        run_search(1'b1, 1'b0, cyc);
        check(cyc == NVW*GWD*GROUP_CYC, "R6/R3 latency wide", cyc, NVW*GWD*GROUP_CYC);
        check(int'(mv_x) == 16 && int'(mv_y) == 8, "R3 wide far corner", int'(mv_x), 16);
        check_result(1'b1, "wide");
    endtask

    task automatic t_max_sad();
        int cyc;
        fill_const(0); cur_const(255); write_cur();
        run_search(1'b0, 1'b0, cyc);
        check(best_sad == 16'd65280, "R1 max sad no wrap", int'(best_sad), 65280);
    endtask

    task automatic t_start_busy();
        int cyc;
        logic [15:0] s0;
        logic signed [9:0] x0, y0;
        fill_hash(); cur_from_patch(2, 2); write_cur();
        run_search(1'b0, 1'b1, cyc);
        check(cyc == NVN*GN*GROUP_CYC, "R7 latency unchanged", cyc, NVN*GN*GROUP_CYC);
        check_result(1'b0, "R7 busy start");
        s0 = best_sad; x0 = mv_x; y0 = mv_y;
        for (int n = 0; n < 40; n++) @(negedge clk);
        check(best_sad == s0 && mv_x == x0 && mv_y == y0, "R8 hold after done",
              int'(best_sad), int'(s0));
        check(done == 1'b0, "R7 no second run", int'(done), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact_normal();
        t_masked_slot();
        t_tie_all();
        t_tie_row_order();
        t_wide();
        t_max_sad();
        t_start_busy();
        check(!addr_fault, "R9 window bounds", int'(addr_fault), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule